// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a raw asynchronous serial line carrying 8N1 characters into parallel bytes. It runs on the system clock and advances its bit timing only on a one-cycle tick enable that pulses eight times per bit period. The raw line first passes through a two-flop synchronizer. A frame starts with a falling edge seen on a tick. From that edge the receiver counts sub-bit phases 0 to 7. The edges inside the frame are not tracked.

Each bit is decided by a majority vote of three samples, taken on phases 3, 4 and 5, which sit around the bit centre. The start bit is checked the same way, so a short low pulse on an idle line is rejected. The first data bit therefore lands 1.5 bit periods after the start edge, and each later bit lands one bit period after the one before it. A high stop bit delivers the byte with a single-cycle valid strobe. A low stop bit raises a framing-error strobe, or a break strobe when all eight data bits were low too. After either error the receiver stays quiet until the line has gone high again.

Top module: `ovs_uart_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `valid_o`, `frame_err_o` and `break_o` are 0 and `data_o` is 0. A reset in the middle of a frame abandons that frame, and no strobe is produced for it.
- R2: Data bits are sent LSB first, so bit 0 of `data_o` is the first bit after the start bit. When the stop bit is high, `valid_o` pulses for exactly one clock and `data_o` holds the received byte.
- R3: A falling edge whose start bit reads high by majority at the bit centre is a glitch. The receiver returns to idle without any strobe and then receives the next real frame correctly.
- R4: Each bit value is the majority of the samples taken on sub-bit ticks 3, 4 and 5 after the bit boundary. One corrupted tick inside a bit does not change the received byte.
- R5: At most one of `valid_o`, `frame_err_o` and `break_o` is high in any cycle. `data_o` changes only together with `valid_o`, and a framing error or break leaves `data_o` unchanged.
- R6: A low stop bit after a frame with at least one data bit equal to 1 gives a one-clock `frame_err_o` pulse. It gives no `valid_o` and no `break_o`.
- R7: A low stop bit after a frame whose eight data bits are all 0 gives a one-clock `break_o` pulse. It gives no `frame_err_o` and no `valid_o`.
- R8: After a framing error or a break, no new frame starts while the line stays low, however long that lasts. Once the line returns high, the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw serial line, idle high |
| tick_i | input | 1 | One-cycle enable, eight per bit period |
| data_o | output | DATA_BITS | Last byte received with a good stop bit |
| valid_o | output | 1 | One-clock strobe: new byte on `data_o` |
| frame_err_o | output | 1 | One-clock strobe: stop bit low, data not all zero |
| break_o | output | 1 | One-clock strobe: stop bit low, data all zero |

## Verification
A phase counter that is off by even one tick moves the voting window towards a bit edge. Because of that, a bench pulse placed at a bit centre starts to corrupt bytes. A wrong bit order shows up in the first asymmetric byte within one frame time.

Several faults can confuse the two error kinds. If the zero test or the state that follows an error is wrong, a break may be reported as a framing error, an error may overwrite `data_o`, or a burst of extra strobes may appear while the line is held low. All of these are visible within one bit period of the stop-bit centre, or during the long low stretch that follows.

A glitch filter that does not work gives a spurious strobe about a frame time after the pulse. It may also shift the alignment of the next real byte.

// File: rtl/ovsrx_pkg.sv
package ovsrx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_HOLD
   } rx_state_e;
endpackage

// File: rtl/ovsrx_sync.sv
module ovsrx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ovsrx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ovsrx_vote.sv
module ovsrx_vote #(
   parameter int OVS  = 8,
   parameter bit MAJ3 = 1'b1
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   tick_i,
   input  logic [$clog2(OVS)-1:0] phase_i,
   input  logic                   line_i,
   output logic                   decide_o,
   output logic                   bit_o
);
   localparam int PW  = $clog2(OVS);
   localparam int MID = OVS / 2;

   generate
      if (MAJ3) begin : g_maj3
         localparam logic [PW-1:0] PH_FIRST = PW'(MID - 1);
         localparam logic [PW-1:0] PH_MID   = PW'(MID);
         localparam logic [PW-1:0] PH_LAST  = PW'(MID + 1);
         logic [1:0] ones_q;
         logic [1:0] sum;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ones_q <= 2'd0;
            end else if (tick_i) begin
               if (phase_i == PH_FIRST)    ones_q <= {1'b0, line_i};
               else if (phase_i == PH_MID) ones_q <= ones_q + {1'b0, line_i};
            end
         end

         assign sum      = ones_q + {1'b0, line_i};
         assign bit_o    = sum[1];
         assign decide_o = tick_i && (phase_i == PH_LAST);
      end else begin : g_single
         localparam logic [PW-1:0] PH_MID = PW'(MID);
         assign bit_o    = line_i;
         assign decide_o = tick_i && (phase_i == PH_MID);
      end
   endgenerate
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
   import ovsrx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OVS         = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJ3        = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 rx_i,
   input  logic                 tick_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 frame_err_o,
   output logic                 break_o
);
   localparam int PW = $clog2(OVS);
   localparam int BW = $clog2(DATA_BITS);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("ovs_uart_rx: OVS must be a power of two, at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_width
         $error("ovs_uart_rx: DATA_BITS must be at least 2");
      end
   endgenerate

   logic                 rxs;
   logic                 prev_q;
   rx_state_e            st_q;
   logic [PW-1:0]        phase_q;
   logic [BW-1:0]        bit_q;
   logic [DATA_BITS-1:0] shift_q;
   logic [DATA_BITS-1:0] data_q;
   logic                 valid_q, ferr_q, brk_q;
   logic                 decide, vbit, edge_seen;

   ovsrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rx_i),
      .q_o   (rxs)
   );

   ovsrx_vote #(.OVS(OVS), .MAJ3(MAJ3)) u_vote (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .phase_i (phase_q),
      .line_i  (rxs),
      .decide_o(decide),
      .bit_o   (vbit)
   );

   assign edge_seen = tick_i && prev_q && !rxs;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         prev_q  <= 1'b1;
         phase_q <= '0;
         bit_q   <= '0;
         shift_q <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
         brk_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
         brk_q   <= 1'b0;
         if (tick_i) prev_q <= rxs;
         unique case (st_q)
            ST_IDLE: begin
               phase_q <= '0;
               if (edge_seen) begin
                  st_q    <= ST_START;
                  phase_q <= PW'(1);
               end
            end
            ST_START: begin
               if (tick_i) phase_q <= phase_q + PW'(1);
               if (decide) begin
                  if (vbit) begin
                     st_q    <= ST_IDLE;
                     phase_q <= '0;
                  end else begin
                     st_q  <= ST_DATA;
                     bit_q <= '0;
                  end
               end
            end
            ST_DATA: begin
               if (tick_i) phase_q <= phase_q + PW'(1);
               if (decide) begin
                  shift_q <= {vbit, shift_q[DATA_BITS-1:1]};
                  if (bit_q == LAST_BIT) st_q  <= ST_STOP;
                  else                   bit_q <= bit_q + BW'(1);
               end
            end
            ST_STOP: begin
               if (tick_i) phase_q <= phase_q + PW'(1);
               if (decide) begin
                  phase_q <= '0;
                  if (vbit) begin
                     valid_q <= 1'b1;
                     data_q  <= shift_q;
                     st_q    <= ST_IDLE;
                  end else begin
                     if (shift_q == '0) brk_q  <= 1'b1;
                     else               ferr_q <= 1'b1;
                     st_q <= ST_HOLD;
                  end
               end
            end
            ST_HOLD: begin
               phase_q <= '0;
               if (rxs) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign data_o      = data_q;
   assign valid_o     = valid_q;
   assign frame_err_o = ferr_q;
   assign break_o     = brk_q;
endmodule

// File: rtl/ovs_uart_rx_chk.sv
module ovs_uart_rx_chk
   import ovsrx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 valid_o,
   input logic                 frame_err_o,
   input logic                 break_o,
   input logic [DATA_BITS-1:0] data_o,
   input rx_state_e            st_i,
   input logic                 line_i,
   input logic [DATA_BITS-1:0] shift_i
);
   AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({valid_o, frame_err_o, break_o})); // R5
   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o); // R2
   AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(data_o)); // R5
   AST_BREAK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      break_o |-> (shift_i == '0)); // R7
   AST_FERR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_err_o |-> (shift_i != '0)); // R6
   AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i == ST_HOLD && !line_i) |=> (st_i == ST_HOLD)); // R8
   AST_ERR_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_err_o || break_o) |-> (st_i == ST_HOLD || st_i == ST_IDLE)); // R8
endmodule

bind ovs_uart_rx ovs_uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .valid_o    (valid_o),
   .frame_err_o(frame_err_o),
   .break_o    (break_o),
   .data_o     (data_o),
   .st_i       (st_q),
   .line_i     (rxs),
   .shift_i    (shift_q)
);

// File: tb/ovs_uart_rx_tb_top.sv
module ovs_uart_rx_tb_top;
   localparam int BITCLK = 32;   // 8 ticks x 4 clocks
   localparam int NV     = 8;
   localparam logic [7:0] V_DATA [NV] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'h00};
   localparam logic       V_STOP [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam int         V_KIND [NV] = '{0, 0, 0, 0, 0, 0, 1, 2}; // 0 byte, 1 framing, 2 break

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick = 1'b0;
   logic [7:0] data_o;
   logic       valid_o, frame_err_o, break_o;

   int checks = 0;
   int errors = 0;
   int n_valid = 0, n_ferr = 0, n_brk = 0;
   logic [7:0] last_data = 8'h00;
   bit done = 1'b0;

   ovs_uart_rx dut_i (
      .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
      .data_o(data_o), .valid_o(valid_o),
      .frame_err_o(frame_err_o), .break_o(break_o)
   );

   always #2 clk = ~clk;

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc = tc + 1;
         tick = (tc % 4 == 0);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (valid_o) begin
            n_valid = n_valid + 1;
            last_data = data_o;
         end
         if (frame_err_o) n_ferr = n_ferr + 1;
         if (break_o)     n_brk = n_brk + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // start bit, 8 data bits LSB first, stop bit; optional 4-clock inversion
   // at the centre of bit index gbit (0 = start, 1..8 = data, 9 = stop)
   task automatic send_frame(input logic [7:0] d, input logic stop, input int gbit);
      for (int i = 0; i < 10; i++) begin
         logic lvl;
         lvl = (i == 0) ? 1'b0 : (i == 9) ? stop : d[i-1];
         if (i == gbit) begin
            rx = lvl;  wait_clk(16);
            rx = ~lvl; wait_clk(4);
            rx = lvl;  wait_clk(12);
         end else begin
            rx = lvl;  wait_clk(BITCLK);
         end
      end
   endtask

   task automatic idle_bits(input int n);
      rx = 1'b1;
      wait_clk(n * BITCLK);
   endtask

   task automatic expect_counts(input string req, input int v0, input int f0, input int b0,
                                input int dv, input int df, input int db);
      check(req, n_valid - v0, dv);
      check(req, n_ferr - f0, df);
      check(req, n_brk - b0, db);
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v0, f0, b0;
      logic [7:0] held;
      wait_clk(5);
      // R1: reset state
      check("R1", {valid_o, frame_err_o, break_o}, 0);
      check("R1", data_o, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", {valid_o, frame_err_o, break_o, data_o}, 0);
      idle_bits(2);

      // vector table: R2 byte order and strobes, R6 framing, R7 break
      for (int k = 0; k < NV; k++) begin
         v0 = n_valid; f0 = n_ferr; b0 = n_brk;
         held = last_data;
         send_frame(V_DATA[k], V_STOP[k], -1);
         idle_bits(2);
         if (V_KIND[k] == 0) begin
            expect_counts("R2", v0, f0, b0, 1, 0, 0);
            check("R2", last_data, V_DATA[k]);
            check("R2", data_o, V_DATA[k]);
         end else if (V_KIND[k] == 1) begin
            expect_counts("R6", v0, f0, b0, 0, 1, 0);
            check("R5", data_o, held);   // error leaves data untouched
         end else begin
            expect_counts("R7", v0, f0, b0, 0, 0, 1);
            check("R5", data_o, held);
         end
      end

      // R3: start glitch of two ticks is rejected, then a real frame decodes
      v0 = n_valid; f0 = n_ferr; b0 = n_brk;
      rx = 1'b0; wait_clk(8); idle_bits(12);
      expect_counts("R3", v0, f0, b0, 0, 0, 0);
      send_frame(8'h3C, 1'b1, -1); idle_bits(2);
      check("R3", n_valid - v0, 1);
      check("R3", data_o, 8'h3C);

      // R4: one corrupted tick in a data bit and in the start bit
      v0 = n_valid;
      send_frame(8'hC6, 1'b1, 3); idle_bits(2);
      check("R4", n_valid - v0, 1);
      check("R4", data_o, 8'hC6);
      send_frame(8'h00, 1'b1, 6); idle_bits(2);
      check("R4", data_o, 8'h00);
      send_frame(8'hE1, 1'b1, 0); idle_bits(2);
      check("R4", data_o, 8'hE1);
      check("R4", n_valid - v0, 3);

      // R8: break followed by a long low line, then a good frame
      v0 = n_valid; f0 = n_ferr; b0 = n_brk;
      send_frame(8'h00, 1'b0, -1);
      rx = 1'b0; wait_clk(20 * BITCLK);
      expect_counts("R8", v0, f0, b0, 0, 0, 1);
      idle_bits(2);
      send_frame(8'h96, 1'b1, -1); idle_bits(2);
      expect_counts("R8", v0, f0, b0, 1, 0, 1);
      check("R8", data_o, 8'h96);

      // R8: framing error with stop held low, line then returns high
      v0 = n_valid; f0 = n_ferr; b0 = n_brk;
      send_frame(8'h81, 1'b0, -1);
      rx = 1'b0; wait_clk(6 * BITCLK);
      idle_bits(2);
      send_frame(8'h24, 1'b1, -1); idle_bits(2);
      expect_counts("R8", v0, f0, b0, 1, 1, 0);
      check("R8", data_o, 8'h24);

      // R1: reset in the middle of a frame
      v0 = n_valid; f0 = n_ferr; b0 = n_brk;
      rx = 1'b0; wait_clk(BITCLK);
      rx = 1'b1; wait_clk(2 * BITCLK);
      rst_n = 1'b0; wait_clk(3);
      check("R1", {valid_o, frame_err_o, break_o, data_o}, 0);
      rst_n = 1'b1;
      idle_bits(10);
      expect_counts("R1", v0, f0, b0, 0, 0, 0);
      send_frame(8'h7E, 1'b1, -1); idle_bits(2);
      check("R1", data_o, 8'h7E);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule